// File: doc/BRIEF.md
# Ring Output Link Arbiter

This block sits on the transmit side of one switch port attached to a ringlet. Three queues feed it. The pass-through queue holds traffic that enters from the ringlet and continues around it. The response queue and the request queue hold traffic that arrives from the other ports of the switch. Each cycle the block places at most one 16-bit symbol on the outgoing link, together with a continuation line. The continuation line is high on every symbol of a packet except the last one. A symbol with the line low therefore closes its packet.

The block chooses a source only at a packet boundary. Pass-through traffic has priority whenever a new packet begins. A packet from the response or request queue may start only while the pass-through queue is empty, and a response beats a request. Once a packet has started, the block stays with its source until the closing symbol is sent. When nothing is sent, the link carries an idle symbol with the continuation line low.

Each queue is assumed to present a valid head symbol only when a whole packet is stored behind it. The block pops a queue exactly on the cycles in which that queue's symbol goes out.

Top module: `ring_out_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the link carries IDLE_SYM (default all zeros) and the continuation line is low.
- R2: With no packet in progress, if the pass-through queue is valid, the pass-through queue is popped in that cycle.
- R3: A response or request packet starts only in a cycle where the pass-through queue is not valid.
- R4: With no packet in progress, the pass-through queue empty and both the response and request queues valid, the response queue is popped and the request queue is not.
- R5: After a symbol with the continuation line high has been popped, only the same queue is popped until one of its symbols with the continuation line low has been popped. Other queues wait even when they are valid.
- R6: In a cycle where no queue is popped, the next cycle's link symbol is IDLE_SYM with the continuation line low.
- R7: At most one queue is popped per cycle, and a queue is popped only while its valid input is high.
- R8: The link data and continuation line in the cycle after a pop equal the data and continuation line that the popped queue presented during the pop.
- R9: If the queue that owns an unfinished packet drops its valid input, nothing is popped and idle is sent. The packet then resumes from the same queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byp_valid | input | 1 | Pass-through queue head is valid |
| byp_data | input | 16 | Pass-through queue head symbol |
| byp_cont | input | 1 | Pass-through head is not the last symbol of its packet |
| byp_pop | output | 1 | Pass-through queue head is consumed this cycle |
| rsp_valid | input | 1 | Response queue head is valid |
| rsp_data | input | 16 | Response queue head symbol |
| rsp_cont | input | 1 | Response head is not the last symbol of its packet |
| rsp_pop | output | 1 | Response queue head is consumed this cycle |
| req_valid | input | 1 | Request queue head is valid |
| req_data | input | 16 | Request queue head symbol |
| req_cont | input | 1 | Request head is not the last symbol of its packet |
| req_pop | output | 1 | Request queue head is consumed this cycle |
| link_data | output | 16 | Outgoing link symbol (registered) |
| link_cont | output | 1 | Outgoing continuation line (registered) |

## Verification
A reference model in the bench follows packet ownership and predicts every pop and every link symbol. The stimulus starts with single-source packets, which confirm that symbols pass through in order with one cycle of delay. Two-source collisions at a boundary then separate pass-through priority from response-over-request priority. Pass-through traffic injected in the middle of a request packet shows that the packet is held to its end rather than preempted. A valid line withdrawn in the middle of a packet shows that the link stalls with idle and does not hand over to another queue. A sweep over all eight combinations of occupied queues, with several packet lengths, covers back-to-back boundaries.

// File: rtl/rol_pkg.sv
package rol_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_BYP  = 2'd1,
      SRC_RSP  = 2'd2,
      SRC_REQ  = 2'd3
   } src_e;

   localparam int NUM_SRC = 3;
endpackage

// File: rtl/rol_select.sv
module rol_select
   import rol_pkg::*;
(
   input  src_e owner,
   input  logic byp_v,
   input  logic rsp_v,
   input  logic req_v,
   output src_e pick
);
   always_comb begin
      if (owner != SRC_NONE)
         pick = owner;
      else if (byp_v)
         pick = SRC_BYP;
      else if (rsp_v)
         pick = SRC_RSP;
      else if (req_v)
         pick = SRC_REQ;
      else
         pick = SRC_NONE;
   end
endmodule

// File: rtl/rol_owner.sv
module rol_owner
   import rol_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  src_e pick,
   input  logic fire,
   input  logic cont,
   output src_e owner
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         owner <= SRC_NONE;
      else if (fire)
         owner <= cont ? pick : SRC_NONE;
   end
endmodule

// File: rtl/rol_link_reg.sv
module rol_link_reg #(
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] IDLE_SYM = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [DATA_W-1:0] sym,
   input  logic              cont,
   output logic [DATA_W-1:0] link_data,
   output logic              link_cont
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_data <= IDLE_SYM;
         link_cont <= 1'b0;
      end else if (fire) begin
         link_data <= sym;
         link_cont <= cont;
      end else begin
         link_data <= IDLE_SYM;
         link_cont <= 1'b0;
      end
   end
endmodule

// File: rtl/ring_out_arbiter.sv
module ring_out_arbiter
   import rol_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] IDLE_SYM = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byp_valid,
   input  logic [DATA_W-1:0] byp_data,
   input  logic              byp_cont,
   output logic              byp_pop,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic              rsp_cont,
   output logic              rsp_pop,
   input  logic              req_valid,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_cont,
   output logic              req_pop,
   output logic [DATA_W-1:0] link_data,
   output logic              link_cont
);
   localparam int SEL_W = $clog2(NUM_SRC + 1);

   initial begin
      if (DATA_W < 8) $error("DATA_W must be at least 8");
      if (SEL_W != 2) $error("source encoding must fit two bits");
   end

   src_e owner;
   src_e pick;

   logic [NUM_SRC-1:0]             src_v;
   logic [NUM_SRC-1:0]             src_c;
   logic [NUM_SRC-1:0][DATA_W-1:0] src_d;
   logic [NUM_SRC-1:0]             pops;
   logic                           fire;
   logic [DATA_W-1:0]              fire_d;
   logic                           fire_c;

   assign src_v = {req_valid, rsp_valid, byp_valid};
   assign src_c = {req_cont,  rsp_cont,  byp_cont};
   assign src_d = {req_data,  rsp_data,  byp_data};

   rol_select u_select (
      .owner (owner),
      .byp_v (byp_valid),
      .rsp_v (rsp_valid),
      .req_v (req_valid),
      .pick  (pick)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_pop
      assign pops[i] = (pick == src_e'(i + 1)) && src_v[i];
   end

   always_comb begin
      fire_d = IDLE_SYM;
      fire_c = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (pops[i]) begin
            fire_d = src_d[i];
            fire_c = src_c[i];
         end
      end
   end

   assign fire    = |pops;
   assign byp_pop = pops[0];
   assign rsp_pop = pops[1];
   assign req_pop = pops[2];

   rol_owner u_owner (
      .clk   (clk),
      .rst_n (rst_n),
      .pick  (pick),
      .fire  (fire),
      .cont  (fire_c),
      .owner (owner)
   );

   rol_link_reg #(.DATA_W(DATA_W), .IDLE_SYM(IDLE_SYM)) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .sym       (fire_d),
      .cont      (fire_c),
      .link_data (link_data),
      .link_cont (link_cont)
   );
endmodule

// File: rtl/ring_out_arbiter_chk.sv
module ring_out_arbiter_chk #(
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] IDLE_SYM = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              byp_valid,
   input logic [DATA_W-1:0] byp_data,
   input logic              byp_cont,
   input logic              byp_pop,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_data,
   input logic              rsp_cont,
   input logic              rsp_pop,
   input logic              req_valid,
   input logic [DATA_W-1:0] req_data,
   input logic              req_cont,
   input logic              req_pop,
   input logic [DATA_W-1:0] link_data,
   input logic              link_cont
);
   // packet ownership, rebuilt from the pop strobes and continuation lines
   logic [2:0] own_mask;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         own_mask <= 3'b000;
      else if (byp_pop)
         own_mask <= byp_cont ? 3'b001 : 3'b000;
      else if (rsp_pop)
         own_mask <= rsp_cont ? 3'b010 : 3'b000;
      else if (req_pop)
         own_mask <= req_cont ? 3'b100 : 3'b000;
   end

   logic [2:0] pops;
   assign pops = {req_pop, rsp_pop, byp_pop};

   p_one_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pops));
   p_pop_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !((byp_pop && !byp_valid) || (rsp_pop && !rsp_valid) || (req_pop && !req_valid)));
   p_byp_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (own_mask == 3'b000 && byp_valid) |-> byp_pop);
   p_byp_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (own_mask == 3'b000 && (rsp_pop || req_pop)) |-> !byp_valid);
   p_rsp_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (own_mask == 3'b000 && !byp_valid && rsp_valid) |-> (rsp_pop && !req_pop));
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (own_mask != 3'b000) |-> ((pops & ~own_mask) == 3'b000));
   p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (own_mask != 3'b000 && (({req_valid, rsp_valid, byp_valid} & own_mask) == 3'b000))
         |-> (pops == 3'b000));
   p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pops == 3'b000) |=> (link_data == IDLE_SYM && !link_cont));
   p_byp_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
      byp_pop |=> (link_data == $past(byp_data) && link_cont == $past(byp_cont)));
   p_rsp_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_pop |=> (link_data == $past(rsp_data) && link_cont == $past(rsp_cont)));
   p_req_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_pop |=> (link_data == $past(req_data) && link_cont == $past(req_cont)));
endmodule

bind ring_out_arbiter ring_out_arbiter_chk #(.DATA_W(DATA_W), .IDLE_SYM(IDLE_SYM)) u_chk (.*);

// File: tb/ring_out_arbiter_test.sv
module ring_out_arbiter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byp_valid = 0, rsp_valid = 0, req_valid = 0;
   logic [15:0] byp_data = 0, rsp_data = 0, req_data = 0;
   logic        byp_cont = 0, rsp_cont = 0, req_cont = 0;
   logic        byp_pop, rsp_pop, req_pop;
   logic [15:0] link_data;
   logic        link_cont;

   always #5 clk = ~clk;

   ring_out_arbiter uut (.*);

   int compared = 0;
   int mismatched = 0;
   logic done = 1'b0;

   logic [16:0] qb[$];
   logic [16:0] qs[$];
   logic [16:0] qr[$];
   logic [2:0]  gate = 3'b111;

   int          m_own = 0;
   logic [15:0] exp_d = 16'h0;
   logic        exp_c = 1'b0;
   string       exp_tag = "R1";
   int          pkt_no = 0;

   task automatic chk(input logic ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic push(input int src, input int len);
      pkt_no++;
      for (int k = 0; k < len; k++) begin
         logic [16:0] s;
         s = {(k != len - 1), 4'(src + 1), 7'(pkt_no), 5'(k) | 5'h10};
         case (src)
            0: qb.push_back(s);
            1: qs.push_back(s);
            default: qr.push_back(s);
         endcase
      end
   endtask

   task automatic step();
      logic [2:0] v;
      logic [2:0] expp;
      int         pk;
      string      tg;
      logic [16:0] sym;
      @(negedge clk);
      chk(link_data == exp_d && link_cont == exp_c, exp_tag, "link",
          {15'd0, link_cont, link_data}, {15'd0, exp_c, exp_d});
      v[0] = gate[0] && qb.size() > 0;
      v[1] = gate[1] && qs.size() > 0;
      v[2] = gate[2] && qr.size() > 0;
      byp_valid = v[0]; byp_data = v[0] ? qb[0][15:0] : 16'h0; byp_cont = v[0] ? qb[0][16] : 1'b0;
      rsp_valid = v[1]; rsp_data = v[1] ? qs[0][15:0] : 16'h0; rsp_cont = v[1] ? qs[0][16] : 1'b0;
      req_valid = v[2]; req_data = v[2] ? qr[0][15:0] : 16'h0; req_cont = v[2] ? qr[0][16] : 1'b0;
      #1;
      if (m_own != 0) pk = m_own;
      else if (v[0]) pk = 1;
      else if (v[1]) pk = 2;
      else if (v[2]) pk = 3;
      else pk = 0;
      expp = 3'b000;
      if (pk != 0 && v[pk-1]) expp[pk-1] = 1'b1;
      if (m_own != 0 && !v[m_own-1]) tg = "R9";
      else if (m_own != 0) tg = "R5";
      else if (pk == 1) tg = "R2";
      else if (pk == 2) tg = "R4";
      else if (pk == 3) tg = "R3";
      else tg = "R6";
      chk({req_pop, rsp_pop, byp_pop} == expp, tg, "pops",
          {29'd0, req_pop, rsp_pop, byp_pop}, {29'd0, expp});
      if (expp != 3'b000) begin
         case (pk)
            1: sym = qb.pop_front();
            2: sym = qs.pop_front();
            default: sym = qr.pop_front();
         endcase
         exp_d = sym[15:0];
         exp_c = sym[16];
         exp_tag = "R8";
         m_own = sym[16] ? pk : 0;
      end else begin
         exp_d = 16'h0;
         exp_c = 1'b0;
         exp_tag = "R6";
      end
   endtask

   task automatic drain();
      int guard = 0;
      while ((qb.size() + qs.size() + qr.size()) > 0 && guard < 200) begin
         step();
         guard++;
      end
      step();
      step();
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog: run did not complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      // R1: link idle during and right after reset, even with a source valid
      byp_valid = 1'b1; byp_data = 16'h5a5a; byp_cont = 1'b1;
      repeat (3) @(negedge clk);
      chk(link_data == 16'h0 && !link_cont, "R1", "link in reset",
          {15'd0, link_cont, link_data}, 32'h0);
      byp_valid = 1'b0; byp_data = 16'h0; byp_cont = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk(link_data == 16'h0 && !link_cont, "R1", "link after reset",
          {15'd0, link_cont, link_data}, 32'h0);
      exp_tag = "R6";

      // R6: nothing queued
      repeat (3) step();
      // R2, R8: pass-through alone
      push(0, 3); drain();
      // R3: request alone
      push(2, 4); drain();
      // R4: response beats request
      push(2, 2); push(1, 3); drain();
      // R2, R3: pass-through beats both output queues
      push(2, 3); push(1, 2); push(0, 2); drain();
      // R5: pass-through arriving mid request waits
      push(2, 5); step(); step(); push(0, 3); push(1, 2); drain();
      // R9: owner underflow mid packet stalls with idle
      push(2, 4); step(); step();
      gate = 3'b011; push(0, 2); push(1, 2);
      step(); step(); step();
      gate = 3'b111; drain();
      // R7: single-symbol packets back to back
      push(1, 1); push(1, 1); push(2, 1); push(0, 1); drain();
      // sweep over all occupancy combinations and lengths
      for (int m = 0; m < 8; m++) begin
         for (int len = 1; len <= 4; len++) begin
            if (m[0]) push(0, len);
            if (m[1]) push(1, len + 1);
            if (m[2]) push(2, len + 2);
            drain();
         end
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule